// File: doc/BRIEF.md
# DDR2 DLL Re-lock and Termination Command Guard

This block sits on the command path between a DDR2 memory controller's scheduler and the DRAM pins. Every command that the scheduler offers is inspected in the cycle it is offered. Commands that are safe go straight out in that cycle. A command that would break a DLL or termination rule is held, with `req_ready` low, until the rule is met. The block watches mode-register writes as they pass. From them it keeps the DLL enable, drive strength, termination selection, strobe and output-disable settings, and it reports those settings as decoded status. The same writes start the waiting periods that the DRAM needs after a DLL reset, after self-refresh exit and after termination is switched on.

A small power-state machine follows the command stream and CKE. It has five states: IDLE (all banks precharged), ACTIVE (at least one bank open), ACT_PD (active power-down), PRE_PD (precharge power-down) and SELF_REF. The transitions are as follows. IDLE goes to ACTIVE on an accepted ACTIVATE. IDLE goes to SELF_REF on an accepted REFRESH with CKE falling. IDLE goes to PRE_PD on any other accepted command with CKE falling. ACTIVE goes to IDLE when a PRECHARGE closes the last open bank, and to ACT_PD on CKE falling. ACT_PD returns to ACTIVE on CKE rising. PRE_PD returns to IDLE on CKE rising. SELF_REF returns to IDLE on CKE rising, and that exit restarts the DLL re-lock wait.

The ODT request from the controller reaches the ODT pin only under three conditions: termination is enabled, the termination hold-off has elapsed, and the state is ACTIVE, ACT_PD or PRE_PD.

Top module: `ddr2g_cmd_guard`

## Requirements
- R1: Command codes are NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4, REFRESH=5, LOAD MODE=6. A command offered with `req_valid` high and `req_ready` high appears on `out_valid`/`out_cmd`/`out_ba`/`out_addr`/`out_cke` in the same cycle, unchanged. Only READ and self-refresh entry are ever stalled.
- R2: A LOAD MODE with bank address 1 updates the extended settings from the address bits. Bit 0 = 0 enables the DLL (`dll_on`), bit 1 = 1 selects reduced drive, bit 10 = 1 disables the complementary strobe, bit 11 = 1 enables the read strobe, and bit 12 = 1 turns all outputs off. Each setting shows on its status output from the cycle after the write. A LOAD MODE with bank address 0 leaves these settings unchanged.
- R3: The termination code is {addr[6], addr[2]}, and `rtt_sel` reports it as 0 off, 1 75 Ω, 2 150 Ω, 3 50 Ω. With RTT50_OK=0, code 3 is reserved. Writing the reserved code pulses `rtt_err` for exactly one cycle and sets `rtt_sel` to 0.
- R4: A LOAD MODE with bank address 0 and addr[8]=1, accepted while `dll_on` is 1, stalls READ for the next LOCK_CYCLES (200) cycles. A READ is accepted from the following cycle onward. The same write while `dll_on` is 0 stalls nothing.
- R5: Leaving self-refresh (CKE rising in SELF_REF) restarts the same LOCK_CYCLES READ stall.
- R6: An accepted extended write that selects a nonzero termination forces `odt_pin` low for the next ODT_HOLD (8) cycles, whatever the request.
- R7: `odt_pin` equals `odt_req` only when termination is enabled, no hold-off is running and the state is ACTIVE, ACT_PD or PRE_PD. In every other case it is 0.
- R8: A REFRESH with CKE falling in IDLE is accepted only if `odt_pin` was low in the previous cycle. Otherwise it is stalled.
- R9: A stalled command is not lost. `out_valid` stays low, `out_cke` keeps its last driven level, and the command issues once `req_ready` rises.
- R10: The power state follows the transitions listed above. It is observable through `odt_pin` under R7.
- R11: After reset, `dll_on`=1, the other settings are 0, `rtt_sel`=0, `out_cke`=1, `odt_pin`=0 and `out_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Command offered |
| req_cmd | input | 3 | Offered command code |
| req_ba | input | BA_W | Offered bank address |
| req_addr | input | ADDR_W | Offered address |
| req_cke | input | 1 | CKE level wanted with this command |
| req_ready | output | 1 | Offered command may issue this cycle |
| out_valid | output | 1 | Command issued to the DRAM this cycle |
| out_cmd | output | 3 | Issued command code (NOP when none) |
| out_ba | output | BA_W | Issued bank address |
| out_addr | output | ADDR_W | Issued address |
| out_cke | output | 1 | CKE pin level |
| odt_req | input | 1 | Controller's termination request |
| odt_pin | output | 1 | ODT pin level |
| dll_on | output | 1 | DLL enabled by the last extended write |
| drive_reduced | output | 1 | Reduced drive strength selected |
| dqsn_off | output | 1 | Complementary strobe disabled |
| rdqs_on | output | 1 | Read strobe enabled |
| outputs_off | output | 1 | All DRAM outputs disabled |
| rtt_sel | output | 2 | Selected termination code |
| rtt_err | output | 1 | One-cycle flag for a reserved termination code |

## Verification
The bench builds the block with its defaults: LOCK_CYCLES=200, ODT_HOLD=8, RTT50_OK=0 and a 13-bit address over eight banks. With these values the full 200-cycle re-lock window is counted cycle by cycle, once after a DLL reset and once after self-refresh exit. The eight-cycle termination hold-off is counted the same way. Because RTT50_OK=0, code 3 is reserved, so the reserved-code error path is exercised. Random streams of the unstalled command types check pass-through, and check ODT gating against a bench model of open banks.

// File: rtl/ddr2g_pkg.sv
package ddr2g_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_ACT   = 3'd1,
        CMD_READ  = 3'd2,
        CMD_WRITE = 3'd3,
        CMD_PRE   = 3'd4,
        CMD_REF   = 3'd5,
        CMD_LMR   = 3'd6,
        CMD_RSV   = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        PS_IDLE     = 3'd0,
        PS_ACTIVE   = 3'd1,
        PS_ACT_PD   = 3'd2,
        PS_PRE_PD   = 3'd3,
        PS_SELF_REF = 3'd4
    } pstate_e;

    // register selection on the low bank-address bits
    localparam logic [1:0] SEL_MR  = 2'd0;
    localparam logic [1:0] SEL_EMR = 2'd1;

    // address bit positions decoded by the DRAM
    localparam int MR_DLL_RST   = 8;
    localparam int PRE_ALL      = 10;
    localparam int EMR_DLL_DIS  = 0;
    localparam int EMR_DRV_RED  = 1;
    localparam int EMR_RTT_LO   = 2;
    localparam int EMR_RTT_HI   = 6;
    localparam int EMR_DQSN_DIS = 10;
    localparam int EMR_RDQS_EN  = 11;
    localparam int EMR_QOFF     = 12;

    localparam logic [1:0] RTT_OFF = 2'b00;
    localparam logic [1:0] RTT_50  = 2'b11;

endpackage

// File: rtl/ddr2g_holdoff.sv
module ddr2g_holdoff #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/ddr2g_mode_decode.sv
module ddr2g_mode_decode
    import ddr2g_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int BA_W     = 3,
    parameter bit RTT50_OK = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    output logic              dll_on,
    output logic              drive_reduced,
    output logic              dqsn_off,
    output logic              rdqs_on,
    output logic              outputs_off,
    output logic [1:0]        rtt_sel,
    output logic              rtt_err,
    output logic              dll_reset_req,
    output logic              odt_arm
);
    logic       is_mr, is_emr;
    logic [1:0] rtt_in, rtt_eff;
    logic       rtt_bad;

    always_comb begin
        is_mr   = wr_en && (ba[1:0] == SEL_MR);
        is_emr  = wr_en && (ba[1:0] == SEL_EMR);
        rtt_in  = {addr[EMR_RTT_HI], addr[EMR_RTT_LO]};
        rtt_bad = !RTT50_OK && (rtt_in == RTT_50);
        rtt_eff = rtt_bad ? RTT_OFF : rtt_in;
        dll_reset_req = is_mr && addr[MR_DLL_RST] && dll_on;
        odt_arm       = is_emr && (rtt_eff != RTT_OFF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dll_on        <= 1'b1;
            drive_reduced <= 1'b0;
            dqsn_off      <= 1'b0;
            rdqs_on       <= 1'b0;
            outputs_off   <= 1'b0;
            rtt_sel       <= RTT_OFF;
            rtt_err       <= 1'b0;
        end else begin
            rtt_err <= is_emr && rtt_bad;
            if (is_emr) begin
                dll_on        <= !addr[EMR_DLL_DIS];
                drive_reduced <= addr[EMR_DRV_RED];
                dqsn_off      <= addr[EMR_DQSN_DIS];
                rdqs_on       <= addr[EMR_RDQS_EN];
                outputs_off   <= addr[EMR_QOFF];
                rtt_sel       <= rtt_eff;
            end
        end
    end
endmodule

// File: rtl/ddr2g_cmd_guard.sv
module ddr2g_cmd_guard
    import ddr2g_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int BA_W        = 3,
    parameter int LOCK_CYCLES = 200,
    parameter int ODT_HOLD    = 8,
    parameter bit RTT50_OK    = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_cmd,
    input  logic [BA_W-1:0]   req_ba,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_cke,
    output logic              req_ready,
    output logic              out_valid,
    output logic [2:0]        out_cmd,
    output logic [BA_W-1:0]   out_ba,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_cke,
    input  logic              odt_req,
    output logic              odt_pin,
    output logic              dll_on,
    output logic              drive_reduced,
    output logic              dqsn_off,
    output logic              rdqs_on,
    output logic              outputs_off,
    output logic [1:0]        rtt_sel,
    output logic              rtt_err
);
    localparam int NBANK = 1 << BA_W;

    cmd_e              cmd;
    pstate_e           state_q, state_nxt;
    logic [NBANK-1:0]  open_q, open_nxt;
    logic              cke_q;
    logic              odt_low_q;
    logic              fire, cke_fall, cke_rise, sre_req, sr_exit;
    logic              lock_busy, hold_busy;
    logic              dll_reset_req, odt_arm;
    logic              odt_state_ok;

    assign cmd      = cmd_e'(req_cmd);
    assign fire     = req_valid && req_ready;
    assign cke_fall = cke_q && !req_cke;
    assign cke_rise = !cke_q && req_cke;
    assign sr_exit  = fire && (state_q == PS_SELF_REF) && cke_rise;

    ddr2g_mode_decode #(
        .ADDR_W   (ADDR_W),
        .BA_W     (BA_W),
        .RTT50_OK (RTT50_OK)
    ) u_mode (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (fire && (cmd == CMD_LMR)),
        .ba            (req_ba),
        .addr          (req_addr),
        .dll_on        (dll_on),
        .drive_reduced (drive_reduced),
        .dqsn_off      (dqsn_off),
        .rdqs_on       (rdqs_on),
        .outputs_off   (outputs_off),
        .rtt_sel       (rtt_sel),
        .rtt_err       (rtt_err),
        .dll_reset_req (dll_reset_req),
        .odt_arm       (odt_arm)
    );

    ddr2g_holdoff #(.CYCLES(LOCK_CYCLES)) u_lock (
        .clk  (clk),
        .rst  (rst),
        .load (dll_reset_req || sr_exit),
        .busy (lock_busy)
    );

    ddr2g_holdoff #(.CYCLES(ODT_HOLD)) u_odt_hold (
        .clk  (clk),
        .rst  (rst),
        .load (odt_arm),
        .busy (hold_busy)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= PS_IDLE;
            open_q    <= '0;
            cke_q     <= 1'b1;
            odt_low_q <= 1'b1;
        end else begin
            state_q   <= state_nxt;
            open_q    <= open_nxt;
            odt_low_q <= !odt_pin;
            if (fire) begin
                cke_q <= req_cke;
            end
        end
    end

    // next state
    always_comb begin
        state_nxt = state_q;
        open_nxt  = open_q;
        if (fire) begin
            if (cmd == CMD_ACT) begin
                open_nxt[req_ba] = 1'b1;
            end else if (cmd == CMD_PRE) begin
                if (req_addr[PRE_ALL]) begin
                    open_nxt = '0;
                end else begin
                    open_nxt[req_ba] = 1'b0;
                end
            end
            unique case (state_q)
                PS_IDLE: begin
                    if (cke_fall) begin
                        state_nxt = (cmd == CMD_REF) ? PS_SELF_REF : PS_PRE_PD;
                    end else if (cmd == CMD_ACT) begin
                        state_nxt = PS_ACTIVE;
                    end
                end
                PS_ACTIVE: begin
                    if (cke_fall) begin
                        state_nxt = PS_ACT_PD;
                    end else if (open_nxt == '0) begin
                        state_nxt = PS_IDLE;
                    end
                end
                PS_ACT_PD: begin
                    if (cke_rise) state_nxt = PS_ACTIVE;
                end
                PS_PRE_PD: begin
                    if (cke_rise) state_nxt = PS_IDLE;
                end
                PS_SELF_REF: begin
                    if (cke_rise) state_nxt = PS_IDLE;
                end
                default: state_nxt = PS_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sre_req = (cmd == CMD_REF) && cke_fall && (state_q == PS_IDLE);
        req_ready = !(((cmd == CMD_READ) && lock_busy) ||
                      (sre_req && !odt_low_q));

        out_valid = fire;
        out_cmd   = fire ? req_cmd : CMD_NOP;
        out_ba    = req_ba;
        out_addr  = req_addr;
        out_cke   = fire ? req_cke : cke_q;

        unique case (state_q)
            PS_ACTIVE, PS_ACT_PD, PS_PRE_PD: odt_state_ok = 1'b1;
            default:                         odt_state_ok = 1'b0;
        endcase
        odt_pin = odt_req && odt_state_ok && (rtt_sel != RTT_OFF) && !hold_busy;
    end
endmodule

// File: rtl/ddr2g_cmd_guard_chk.sv
module ddr2g_cmd_guard_chk #(
    parameter int ADDR_W      = 13,
    parameter int BA_W        = 3,
    parameter int LOCK_CYCLES = 200,
    parameter int ODT_HOLD    = 8,
    parameter bit RTT50_OK    = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [2:0]        req_cmd,
    input logic [BA_W-1:0]   req_ba,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_cke,
    input logic              req_ready,
    input logic              out_valid,
    input logic [2:0]        out_cmd,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_cke,
    input logic              odt_pin,
    input logic              dll_on,
    input logic [1:0]        rtt_sel,
    input logic              rtt_err,
    input logic [2:0]        state
);
    logic        acc;
    logic        mr_rst, emr_on, sr_leave;
    logic [1:0]  rtt_wr;
    logic [15:0] lk_cnt, oh_cnt;

    assign acc      = req_valid && req_ready;
    assign rtt_wr   = {req_addr[6], req_addr[2]};
    assign mr_rst   = acc && (req_cmd == 3'd6) && (req_ba[1:0] == 2'd0) && req_addr[8] && dll_on;
    assign emr_on   = acc && (req_cmd == 3'd6) && (req_ba[1:0] == 2'd1) &&
                      (rtt_wr != 2'b00) && (RTT50_OK || rtt_wr != 2'b11);
    assign sr_leave = acc && (state == 3'd4) && req_cke;

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_cnt <= '0;
            oh_cnt <= '0;
        end else begin
            if (mr_rst || sr_leave) lk_cnt <= 16'(LOCK_CYCLES);
            else if (lk_cnt != '0)  lk_cnt <= lk_cnt - 1'b1;
            if (emr_on)             oh_cnt <= 16'(ODT_HOLD);
            else if (oh_cnt != '0)  oh_cnt <= oh_cnt - 1'b1;
        end
    end

    AST_PASS_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        acc |-> (out_valid && out_cmd == req_cmd && out_addr == req_addr && out_cke == req_cke)); // R1

    AST_READ_LOCK_WAIT: assert property (@(posedge clk) disable iff (rst)
        (lk_cnt != '0 && req_valid && req_cmd == 3'd2) |-> !req_ready); // R4

    AST_ODT_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
        (oh_cnt != '0) |-> !odt_pin); // R6

    AST_ODT_STATE_GATE: assert property (@(posedge clk) disable iff (rst)
        odt_pin |-> (state == 3'd1 || state == 3'd2 || state == 3'd3)); // R7

    AST_SRE_AFTER_ODT_LOW: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_cmd == 3'd5 && !out_cke && $past(out_cke)) |-> $past(!odt_pin)); // R8

    AST_STALL_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |-> (!out_valid && out_cke == $past(out_cke))); // R9

    AST_RESERVED_RTT_OFF: assert property (@(posedge clk) disable iff (rst)
        rtt_err |-> (rtt_sel == 2'b00)); // R3

    AST_RTT_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        rtt_err |=> (!rtt_err || $past(acc && req_cmd == 3'd6))); // R3
endmodule

bind ddr2g_cmd_guard ddr2g_cmd_guard_chk #(
    .ADDR_W      (ADDR_W),
    .BA_W        (BA_W),
    .LOCK_CYCLES (LOCK_CYCLES),
    .ODT_HOLD    (ODT_HOLD),
    .RTT50_OK    (RTT50_OK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_cmd   (req_cmd),
    .req_ba    (req_ba),
    .req_addr  (req_addr),
    .req_cke   (req_cke),
    .req_ready (req_ready),
    .out_valid (out_valid),
    .out_cmd   (out_cmd),
    .out_addr  (out_addr),
    .out_cke   (out_cke),
    .odt_pin   (odt_pin),
    .dll_on    (dll_on),
    .rtt_sel   (rtt_sel),
    .rtt_err   (rtt_err),
    .state     (state_q)
);

// File: tb/ddr2g_cmd_guard_bench.sv
`timescale 1ns/1ps
module ddr2g_cmd_guard_bench;
    localparam int ADDR_W = 13;
    localparam int BA_W   = 3;

    localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                           C_PRE = 3'd4, C_REF = 3'd5, C_LMR = 3'd6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              req_valid = 1'b0;
    logic [2:0]        req_cmd   = 3'd0;
    logic [BA_W-1:0]   req_ba    = '0;
    logic [ADDR_W-1:0] req_addr  = '0;
    logic              req_cke   = 1'b1;
    logic              odt_req   = 1'b0;
    logic              req_ready, out_valid, out_cke, odt_pin;
    logic [2:0]        out_cmd;
    logic [BA_W-1:0]   out_ba;
    logic [ADDR_W-1:0] out_addr;
    logic              dll_on, drive_reduced, dqsn_off, rdqs_on, outputs_off, rtt_err;
    logic [1:0]        rtt_sel;

    int vec = 0;
    int bad = 0;
    bit done = 0;

    ddr2g_cmd_guard u_ddr2g_cmd_guard (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_ba(req_ba), .req_addr(req_addr), .req_cke(req_cke),
        .req_ready(req_ready), .out_valid(out_valid), .out_cmd(out_cmd),
        .out_ba(out_ba), .out_addr(out_addr), .out_cke(out_cke),
        .odt_req(odt_req), .odt_pin(odt_pin), .dll_on(dll_on),
        .drive_reduced(drive_reduced), .dqsn_off(dqsn_off), .rdqs_on(rdqs_on),
        .outputs_off(outputs_off), .rtt_sel(rtt_sel), .rtt_err(rtt_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] emr(input logic dll_dis, input logic drv,
                                              input logic [1:0] rtt, input logic dqsn,
                                              input logic rdqs, input logic qoff);
        logic [ADDR_W-1:0] a = '0;
        a[0] = dll_dis; a[1] = drv; a[2] = rtt[0]; a[6] = rtt[1];
        a[10] = dqsn; a[11] = rdqs; a[12] = qoff;
        return a;
    endfunction

    function automatic logic exp_odt(input logic [7:0] open, input logic req);
        return req && (open != 8'd0);
    endfunction

    task automatic drive(input logic [2:0] c, input logic [BA_W-1:0] b,
                         input logic [ADDR_W-1:0] a, input logic k);
        req_valid = 1'b1; req_cmd = c; req_ba = b; req_addr = a; req_cke = k;
    endtask

    task automatic smp;
        @(negedge clk);
    endtask

    task automatic adv;
        @(posedge clk);
        #1;
    endtask

    task automatic count_read_stall(input string tag);
        int stalls = 0;
        drive(C_RD, 3'd0, '0, 1'b1);
        for (int i = 0; i < 1000; i++) begin
            smp;
            if (req_ready) break;
            stalls++;
            if (out_valid) check({tag, " R9 out_valid during stall"}, out_valid, 0);
            adv;
        end
        check({tag, " read stall cycles"}, stalls, 200);
        check({tag, " R9 held read issues"}, out_valid, 1);
        adv;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] open;
        void'($urandom(32'd5150));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R11 reset state
        odt_req = 1'b1;
        smp;
        check("R11 ready", req_ready, 1);
        check("R11 out_valid", out_valid, 0);
        check("R11 dll_on", dll_on, 1);
        check("R11 rtt_sel", rtt_sel, 0);
        check("R11 odt_pin", odt_pin, 0);
        check("R11 out_cke", out_cke, 1);
        check("R11 flags", {drive_reduced, dqsn_off, rdqs_on, outputs_off, rtt_err}, 0);
        adv;

        // R2 / R3 extended settings
        drive(C_LMR, 3'd1, emr(0, 1, 2'b01, 1, 1, 1), 1'b1);
        smp;
        check("R1 lmr pass", {out_valid, out_cmd}, {1'b1, C_LMR});
        adv;
        drive(C_NOP, 3'd0, '0, 1'b1);
        smp;
        check("R2 settings", {dll_on, drive_reduced, dqsn_off, rdqs_on, outputs_off}, 5'b11111);
        check("R3 rtt 75", rtt_sel, 1);
        adv;
        drive(C_LMR, 3'd0, '0, 1'b1);
        adv;
        drive(C_NOP, 3'd0, '0, 1'b1);
        smp;
        check("R2 MR write keeps EMR", {drive_reduced, outputs_off}, 2'b11);
        adv;
        drive(C_LMR, 3'd1, emr(1, 0, 2'b10, 0, 0, 0), 1'b1);
        adv;
        drive(C_NOP, 3'd0, '0, 1'b1);
        smp;
        check("R2 dll off", {dll_on, drive_reduced, dqsn_off}, 3'b000);
        check("R3 rtt 150", rtt_sel, 2);
        adv;

        // R4 DLL reset with DLL off does not stall
        drive(C_LMR, 3'd0, 13'h100, 1'b1);
        adv;
        drive(C_RD, 3'd0, '0, 1'b1);
        smp;
        check("R4 no stall with dll off", req_ready, 1);
        adv;

        // R3 reserved code
        drive(C_LMR, 3'd1, emr(1, 0, 2'b11, 0, 0, 0), 1'b1);
        adv;
        drive(C_NOP, 3'd0, '0, 1'b1);
        smp;
        check("R3 rtt_err pulse", rtt_err, 1);
        check("R3 reserved -> off", rtt_sel, 0);
        adv;
        smp;
        check("R3 rtt_err one cycle", rtt_err, 0);
        adv;

        // R4 DLL reset with DLL on
        drive(C_LMR, 3'd1, emr(0, 0, 2'b01, 0, 0, 0), 1'b1);
        adv;
        drive(C_LMR, 3'd0, 13'h100, 1'b1);
        adv;
        count_read_stall("R4");

        // R6 termination hold-off, in ACTIVE
        drive(C_ACT, 3'd0, '0, 1'b1);
        adv;
        drive(C_NOP, 3'd0, '0, 1'b1);
        smp;
        check("R7 R10 active odt follows", odt_pin, 1);
        adv;
        drive(C_LMR, 3'd1, emr(0, 0, 2'b10, 0, 0, 0), 1'b1);
        adv;
        drive(C_NOP, 3'd0, '0, 1'b1);
        begin
            int low = 0;
            for (int i = 0; i < 50; i++) begin
                smp;
                if (odt_pin) break;
                low++;
                adv;
            end
            check("R6 odt hold cycles", low, 8);
        end
        adv;

        // R7 / R10 power states
        drive(C_PRE, 3'd0, 13'h400, 1'b1);
        adv;
        drive(C_NOP, 3'd0, '0, 1'b1);
        smp;
        check("R7 R10 idle odt low", odt_pin, 0);
        adv;
        drive(C_NOP, 3'd0, '0, 1'b0);
        adv;
        smp;
        check("R7 R10 precharge pd odt", odt_pin, 1);
        adv;
        drive(C_NOP, 3'd0, '0, 1'b1);
        adv;
        smp;
        check("R7 R10 pd exit to idle", odt_pin, 0);
        adv;
        drive(C_ACT, 3'd2, '0, 1'b1);
        adv;
        drive(C_NOP, 3'd0, '0, 1'b0);
        adv;
        smp;
        check("R7 R10 active pd odt", odt_pin, 1);
        adv;
        drive(C_NOP, 3'd0, '0, 1'b1);
        adv;
        smp;
        check("R7 R10 back to active", odt_pin, 1);
        adv;

        // R8 self-refresh entry waits for ODT low
        drive(C_PRE, 3'd2, '0, 1'b1);
        adv;
        drive(C_REF, 3'd0, '0, 1'b0);
        smp;
        check("R8 sre stalled", req_ready, 0);
        check("R9 stalled no issue", out_valid, 0);
        check("R9 cke held", out_cke, 1);
        adv;
        smp;
        check("R8 sre accepted", {req_ready, out_valid, out_cke}, 3'b110);
        adv;
        drive(C_NOP, 3'd0, '0, 1'b0);
        smp;
        check("R7 R10 self refresh odt low", odt_pin, 0);
        adv;
        drive(C_NOP, 3'd0, '0, 1'b1);
        smp;
        check("R5 exit cke", out_cke, 1);
        adv;
        count_read_stall("R5");

        // R1 random pass-through with ODT model
        open = 8'd0;
        for (int n = 0; n < 400; n++) begin
            logic [2:0] c;
            logic [BA_W-1:0] b;
            logic [ADDR_W-1:0] a;
            logic [2:0] pick = 3'($urandom % 5);
            c = (pick == 3'd0) ? C_NOP : (pick == 3'd1) ? C_ACT :
                (pick == 3'd2) ? C_RD  : (pick == 3'd3) ? C_WR  : C_PRE;
            b = BA_W'($urandom);
            a = ADDR_W'($urandom);
            odt_req = 1'($urandom);
            drive(c, b, a, 1'b1);
            smp;
            check("R1 ready", req_ready, 1);
            check("R1 pass fields", {out_valid, out_cmd, out_ba, out_addr},
                  {1'b1, c, b, a});
            check("R7 random odt", odt_pin, exp_odt(open, odt_req));
            adv;
            if (c == C_ACT) open[b] = 1'b1;
            else if (c == C_PRE) begin
                if (a[10]) open = 8'd0;
                else open[b] = 1'b0;
            end
        end

        req_valid = 1'b0;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule